// File: doc/BRIEF.md
# Indirect-Source DMA Channel

This block is one DMA channel that copies data from memory into a single peripheral register. Each transfer is triggered by a request strobe from that peripheral. The channel uses cycle-steal operation: it performs one transfer per request and then gives up the bus before it takes on the next one. Software programs a source address, a destination address, a transfer count and a control word. A master enable shared with the rest of the system also has to be on before the channel moves anything.

With the indirect option set, the source register does not point at the data itself. It points at a 32-bit pointer. The channel first fetches that pointer as a full word, then reads the data through it, then writes the data to the destination. In that mode the source register moves by four per transfer, whatever unit is configured, because it walks a table of word-sized pointers. Without the option, a transfer is the usual pair of accesses: a read at the source, then a write at the destination.

The transfer count drops by one with each completed transfer. When it reaches zero, the channel raises an end flag and stops accepting requests. It drives a maskable interrupt for as long as that flag stays set.

Top module: `dma_ind_chan`

## Requirements
- R1: With indirect mode on (control bit 1 = 1), one request produces exactly three bus accesses in this order: a read at the source register address, a read at the 32-bit word returned by that first read, and a write at the destination register address.
- R2: The pointer fetch is always a word access (bus_size = 2'b10), whatever the transfer size field holds. The size field is control bits 7:6, encoded 00 = byte, 01 = halfword, 10 = word.
- R3: After each transfer the source register follows source mode (control bits 3:2, encoded 00 = fixed, 01 = increment, 10 = decrement). It steps by 4 in indirect mode, and by the transfer unit in bytes (1, 2 or 4) otherwise.
- R4: The destination register follows destination mode (control bits 5:4, same encoding as source mode) and steps by the transfer unit. In fixed mode it never changes.
- R5: The count register drops by exactly one per completed transfer. The transfer that takes it to zero sets end_flag. While end_flag is set, requests cause no bus access.
- R6: irq equals end_flag gated by interrupt enable (control bit 8). A pulse on clr_end clears end_flag, and with it irq.
- R7: No transfer starts unless both the channel enable (control bit 0) and master_en are 1. A request that arrives while either one is 0 is discarded and is not serviced later.
- R8: Cycle-steal: one request gives exactly one transfer. bus_req drops for at least one cycle after the write of each transfer. While bus_req is high and bus_rdy is low, address and direction hold steady.
- R9: A request that arrives during a transfer is remembered and serviced right after that transfer. Only one request can wait at a time, so further requests during the same transfer are lost.
- R10: The data read takes the addressed lane of the 32-bit bus, little-endian. A byte comes from bits 8*addr[1:0] and up, a halfword from bits 16*addr[1] and up. The write places the value on the lane chosen by the destination address, drives zero on the other lanes, and puts the configured size on bus_size.
- R11: After reset, bus_req, end_flag and irq are 0, and the source, destination and count registers are 0.
- R12: With indirect mode off, one request produces exactly two accesses: a read at the source address in the configured size, then the write at the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | Global DMA enable |
| ld_src | input | 1 | Load source register from cfg_wdata |
| ld_dst | input | 1 | Load destination register from cfg_wdata |
| ld_cnt | input | 1 | Load transfer count from cfg_wdata |
| ld_ctl | input | 1 | Load control word from cfg_wdata |
| clr_end | input | 1 | Clear the end flag |
| cfg_wdata | input | 32 | Configuration write data |
| xfer_req | input | 1 | Peripheral transfer request strobe |
| bus_req | output | 1 | Bus access valid |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_size | output | 2 | Access size: 00 byte, 01 halfword, 10 word |
| bus_addr | output | 32 | Access byte address |
| bus_wdata | output | 32 | Write data, lane placed |
| bus_rdata | input | 32 | Read data, valid with bus_rdy |
| bus_rdy | input | 1 | Access completes in this cycle |
| end_flag | output | 1 | Transfer count exhausted |
| irq | output | 1 | End-of-transfer interrupt |
| cur_src | output | 32 | Current source register |
| cur_dst | output | 32 | Current destination register |
| cur_cnt | output | 16 | Remaining transfer count |

## Verification
A faulty step in the address unit appears on cur_src or cur_dst as soon as a transfer finishes. The following transfer then carries it to bus_addr. A sequencer stuck in the wrong phase, or skipping one, shows on the bus within one transfer as an access with the wrong count, order, size or address. A lost or duplicated request shows up as a count that is off, or as accesses that turn up after the bench has stopped sending requests. Errors in the count or the flag appear on end_flag and irq at the transfer that should have ended the block, or as bus activity after that transfer.

// File: rtl/dma_ind_pkg.sv
// Package: shared widths, control-word layout, sequencer states and lane
// helpers for the indirect-source DMA channel. Assumes a 32-bit little-endian bus.
package dma_ind_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CTL_W  = 9;
    // Control word bit positions
    localparam int C_EN   = 0;
    localparam int C_IND  = 1;
    localparam int C_SM   = 2;
    localparam int C_DM   = 4;
    localparam int C_SZ   = 6;
    localparam int C_IRQ  = 8;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    typedef enum logic [1:0] {ST_IDLE, ST_PTR, ST_RD, ST_WR} seq_state_e;

    // Byte distance of one step
    function automatic logic [ADDR_W-1:0] step_amt(input logic [1:0] sz, input logic ind);
        if (ind)              return ADDR_W'(4);
        else if (sz == SZ_BYTE) return ADDR_W'(1);
        else if (sz == SZ_HALF) return ADDR_W'(2);
        else                    return ADDR_W'(4);
    endfunction

    // Apply an address mode: 01 increment, 10 decrement, else hold
    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                    input logic [1:0] mode,
                                                    input logic [ADDR_W-1:0] amt);
        case (mode)
            2'b01:   return a + amt;
            2'b10:   return a - amt;
            default: return a;
        endcase
    endfunction

    // Pick the addressed lane of a read word, right-aligned
    function automatic logic [DATA_W-1:0] lane_get(input logic [DATA_W-1:0] w,
                                                  input logic [1:0] lo,
                                                  input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return DATA_W'(w >> (8 * lo)) & DATA_W'(32'hFF);
            SZ_HALF: return DATA_W'(w >> (16 * lo[1])) & DATA_W'(32'hFFFF);
            default: return w;
        endcase
    endfunction

    // Place a right-aligned value on the lane chosen by the address
    function automatic logic [DATA_W-1:0] lane_put(input logic [DATA_W-1:0] d,
                                                  input logic [1:0] lo,
                                                  input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return DATA_W'({24'b0, d[7:0]}) << (8 * lo);
            SZ_HALF: return DATA_W'({16'b0, d[15:0]}) << (16 * lo[1]);
            default: return d;
        endcase
    endfunction
endpackage

// File: rtl/dma_req_latch.sv
// Request latch: holds at most one pending request. Requests are discarded
// while the channel cannot accept them (disabled or count ended).
module dma_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic accept,
    input  logic take,
    output logic pend
);
    // Set on request, clear when the sequencer takes it or acceptance drops
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= 1'b0;
        else if (!accept) pend <= 1'b0;
        else              pend <= (pend & ~take) | req;
    end
endmodule

// File: rtl/dma_regs.sv
// Channel registers: source, destination, count and end flag. Updated once
// per completed transfer; software loads take priority over updates.
module dma_regs
    import dma_ind_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_src,
    input  logic              ld_dst,
    input  logic              ld_cnt,
    input  logic              clr_end,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              xfer_done,
    input  logic              ind,
    input  logic [1:0]        src_mode,
    input  logic [1:0]        dst_mode,
    input  logic [1:0]        sz,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              end_q
);
    // Source address register
    always_ff @(posedge clk) begin
        if (!rst_n)         src_q <= '0;
        else if (ld_src)    src_q <= wdata;
        else if (xfer_done) src_q <= next_addr(src_q, src_mode, step_amt(sz, ind));
    end

    // Destination address register
    always_ff @(posedge clk) begin
        if (!rst_n)         dst_q <= '0;
        else if (ld_dst)    dst_q <= wdata;
        else if (xfer_done) dst_q <= next_addr(dst_q, dst_mode, step_amt(sz, 1'b0));
    end

    // Remaining transfer count
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (ld_cnt)    cnt_q <= wdata[CNT_W-1:0];
        else if (xfer_done) cnt_q <= cnt_q - CNT_W'(1);
    end

    // End flag: set by the last transfer, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n)                                end_q <= 1'b0;
        else if (xfer_done && cnt_q == CNT_W'(1))  end_q <= 1'b1;
        else if (clr_end)                          end_q <= 1'b0;
    end
endmodule

// File: rtl/dma_seq.sv
// Transfer sequencer: drives the bus master port through an optional pointer
// fetch, the data read and the write. Assumes bus_rdy completes an access in
// the cycle it is high, with read data valid in that cycle.
module dma_seq
    import dma_ind_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              ind,
    input  logic [1:0]        sz,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_rdy,
    output logic              take,
    output logic              xfer_done,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);
    seq_state_e        state;
    logic [ADDR_W-1:0] ptr_q;
    logic [DATA_W-1:0] data_q;

    assign take      = (state == ST_IDLE) && go;
    assign xfer_done = (state == ST_WR) && bus_rdy;

    // Bus outputs decoded from the current phase
    always_comb begin
        bus_req   = (state != ST_IDLE);
        bus_we    = (state == ST_WR);
        bus_size  = (state == ST_PTR) ? SZ_WORD : sz;
        bus_wdata = '0;
        case (state)
            ST_PTR:  bus_addr = src;
            ST_RD:   bus_addr = ind ? ptr_q : src;
            ST_WR:   begin
                bus_addr  = dst;
                bus_wdata = lane_put(data_q, dst[1:0], sz);
            end
            default: bus_addr = '0;
        endcase
    end

    // Phase sequencing and capture of pointer and data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ptr_q  <= '0;
            data_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (go) state <= ind ? ST_PTR : ST_RD;
                ST_PTR:  if (bus_rdy) begin
                    ptr_q <= bus_rdata;
                    state <= ST_RD;
                end
                ST_RD:   if (bus_rdy) begin
                    data_q <= lane_get(bus_rdata, bus_addr[1:0], sz);
                    state  <= ST_WR;
                end
                default: if (bus_rdy) state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_ind_chan.sv
// Top: single cycle-steal DMA channel with optional indirect source. Holds
// the control word and ties the request latch, registers and sequencer.
module dma_ind_chan
    import dma_ind_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              ld_src,
    input  logic              ld_dst,
    input  logic              ld_cnt,
    input  logic              ld_ctl,
    input  logic              clr_end,
    input  logic [31:0]       cfg_wdata,
    input  logic              xfer_req,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_size,
    output logic [31:0]       bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_rdy,
    output logic              end_flag,
    output logic              irq,
    output logic [31:0]       cur_src,
    output logic [31:0]       cur_dst,
    output logic [CNT_W-1:0]  cur_cnt
);
    logic [CTL_W-1:0] ctl_q;
    logic ch_en, ind_en, irq_en, run, accept, pend, take, xfer_done, go;
    logic [1:0] src_mode, dst_mode, xsize;

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ld_ctl) ctl_q <= cfg_wdata[CTL_W-1:0];
    end

    assign ch_en    = ctl_q[C_EN];
    assign ind_en   = ctl_q[C_IND];
    assign src_mode = ctl_q[C_SM +: 2];
    assign dst_mode = ctl_q[C_DM +: 2];
    assign xsize    = ctl_q[C_SZ +: 2];
    assign irq_en   = ctl_q[C_IRQ];
    assign run      = ch_en && master_en;
    assign accept   = run && !end_flag;
    assign go       = pend && accept && (cur_cnt != '0);
    assign irq      = end_flag && irq_en;

    dma_req_latch u_req (
        .clk(clk), .rst_n(rst_n), .req(xfer_req), .accept(accept),
        .take(take), .pend(pend)
    );

    dma_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ld_src(ld_src), .ld_dst(ld_dst),
        .ld_cnt(ld_cnt), .clr_end(clr_end), .wdata(cfg_wdata),
        .xfer_done(xfer_done), .ind(ind_en), .src_mode(src_mode),
        .dst_mode(dst_mode), .sz(xsize), .src_q(cur_src), .dst_q(cur_dst),
        .cnt_q(cur_cnt), .end_q(end_flag)
    );

    dma_seq u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .ind(ind_en), .sz(xsize),
        .src(cur_src), .dst(cur_dst), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
        .take(take), .xfer_done(xfer_done), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
    );
endmodule

// File: rtl/dma_ind_chan_chk.sv
// Checker: temporal properties of the DMA channel, bound to the top module.
module dma_ind_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_we,
    input logic             bus_rdy,
    input logic [31:0]      bus_addr,
    input logic             master_en,
    input logic             ch_en,
    input logic             irq_en,
    input logic             end_flag,
    input logic             irq,
    input logic [CNT_W-1:0] cur_cnt,
    input logic [31:0]      cur_dst,
    input logic [1:0]       dst_mode,
    input logic             ld_cnt,
    input logic             ld_dst,
    input logic             ld_ctl
);
    a_r8_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_rdy |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_rdy |=> !bus_req);

    a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(master_en && ch_en));

    a_r5_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !$past(end_flag));

    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_rdy && !ld_cnt |=> cur_cnt == $past(cur_cnt) - CNT_W'(1));

    a_r6_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> end_flag && irq_en);

    a_r4_dst_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        dst_mode == 2'b00 && !ld_dst && !ld_ctl |=> $stable(cur_dst));
endmodule

bind dma_ind_chan dma_ind_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_rdy(bus_rdy), .bus_addr(bus_addr), .master_en(master_en),
    .ch_en(ch_en), .irq_en(irq_en), .end_flag(end_flag), .irq(irq),
    .cur_cnt(cur_cnt), .cur_dst(cur_dst), .dst_mode(dst_mode),
    .ld_cnt(ld_cnt), .ld_dst(ld_dst), .ld_ctl(ld_ctl)
);

// File: tb/dma_ind_chan_bench.sv
`timescale 1ns/1ps
module dma_ind_chan_bench;
    logic clk = 0, rst_n = 0, master_en = 0;
    logic ld_src = 0, ld_dst = 0, ld_cnt = 0, ld_ctl = 0, clr_end = 0, xfer_req = 0;
    logic [31:0] cfg_wdata = 0, bus_rdata = 0;
    logic bus_rdy = 0;
    logic bus_req, bus_we, end_flag, irq;
    logic [1:0] bus_size;
    logic [31:0] bus_addr, bus_wdata, cur_src, cur_dst;
    logic [15:0] cur_cnt;

    int checks = 0, fails = 0;
    logic [31:0] mem [0:255];
    logic [31:0] la [0:15];
    logic [31:0] lwd [0:15];
    logic        lw [0:15];
    logic [1:0]  ls [0:15];
    int nlog = 0;
    int wcnt = 0;

    always #5 clk = ~clk;

    dma_ind_chan u_dma_ind_chan (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .ld_src(ld_src),
        .ld_dst(ld_dst), .ld_cnt(ld_cnt), .ld_ctl(ld_ctl), .clr_end(clr_end),
        .cfg_wdata(cfg_wdata), .xfer_req(xfer_req), .bus_req(bus_req),
        .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
        .end_flag(end_flag), .irq(irq), .cur_src(cur_src), .cur_dst(cur_dst),
        .cur_cnt(cur_cnt)
    );

    // Memory responder with random wait states; logs every completed access
    always @(negedge clk) begin
        if (bus_rdy) bus_rdy = 1'b0;
        else if (bus_req && rst_n) begin
            if (wcnt == 0) begin
                bus_rdy = 1'b1;
                bus_rdata = mem[bus_addr[9:2]];
                if (nlog < 16) begin
                    la[nlog] = bus_addr; lw[nlog] = bus_we;
                    ls[nlog] = bus_size; lwd[nlog] = bus_wdata;
                end
                nlog++;
                wcnt = int'($urandom % 3);
            end else wcnt--;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bget(input logic [31:0] w, input logic [31:0] a, input logic [1:0] sz);
        if (sz == 2'd0) return (w >> (8 * a[1:0])) & 32'hFF;
        if (sz == 2'd1) return (w >> (16 * a[1])) & 32'hFFFF;
        return w;
    endfunction

    function automatic logic [31:0] bput(input logic [31:0] d, input logic [31:0] a, input logic [1:0] sz);
        if (sz == 2'd0) return (d & 32'hFF) << (8 * a[1:0]);
        if (sz == 2'd1) return (d & 32'hFFFF) << (16 * a[1]);
        return d;
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] a, input logic [1:0] m, input int unsigned amt);
        if (m == 2'd1) return a + amt;
        if (m == 2'd2) return a - amt;
        return a;
    endfunction

    function automatic int unsigned unit(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_cfg(input int sel, input logic [31:0] v);
        @(negedge clk);
        cfg_wdata = v;
        ld_src = (sel == 0); ld_dst = (sel == 1); ld_cnt = (sel == 2); ld_ctl = (sel == 3);
        @(negedge clk);
        ld_src = 0; ld_dst = 0; ld_cnt = 0; ld_ctl = 0;
    endtask

    function automatic logic [31:0] ctl(input bit en, input bit ind, input logic [1:0] sm,
                                        input logic [1:0] dm, input logic [1:0] sz, input bit ie);
        return {23'b0, ie, sz, dm, sm, ind, en};
    endfunction

    task automatic pulse_req();
        @(negedge clk); xfer_req = 1; @(negedge clk); xfer_req = 0;
    endtask

    // One request, then compare the bus log and registers with the model
    task automatic run_xfer(input bit ind, input logic [1:0] sm, input logic [1:0] dm, input logic [1:0] sz);
        logic [31:0] s, d, p, da, data;
        logic [15:0] c;
        int n, k;
        @(negedge clk);
        s = cur_src; d = cur_dst; c = cur_cnt;
        n = ind ? 3 : 2;
        nlog = 0;
        pulse_req();
        for (int i = 0; i < 300 && nlog < n; i++) @(negedge clk);
        cyc(8);
        chk(nlog == n, ind ? "R1 R8 access count" : "R12 R8 access count", nlog, n);
        k = 0;
        if (ind) begin
            chk(la[0] == s && !lw[0], "R1 pointer fetch address", la[0], s);
            chk(ls[0] == 2'd2, "R2 pointer fetch size", {30'b0, ls[0]}, 2);
            p = mem[s[9:2]];
            da = p; k = 1;
        end else da = s;
        chk(la[k] == da && !lw[k], ind ? "R1 data read address" : "R12 data read address", la[k], da);
        chk(ls[k] == sz, "R10 read size", {30'b0, ls[k]}, {30'b0, sz});
        data = bget(mem[da[9:2]], da, sz);
        chk(la[k+1] == d && lw[k+1], "R1 R12 write address", la[k+1], d);
        chk(ls[k+1] == sz, "R10 write size", {30'b0, ls[k+1]}, {30'b0, sz});
        chk(lwd[k+1] == bput(data, d, sz), "R10 write lane data", lwd[k+1], bput(data, d, sz));
        chk(cur_src == nxt(s, sm, ind ? 4 : unit(sz)), "R3 source step", cur_src, nxt(s, sm, ind ? 4 : unit(sz)));
        chk(cur_dst == nxt(d, dm, unit(sz)), "R4 destination step", cur_dst, nxt(d, dm, unit(sz)));
        chk(cur_cnt == c - 16'd1, "R5 count decrement", {16'b0, cur_cnt}, {16'b0, c - 16'd1});
    endtask

    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] s0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        cyc(4);
        rst_n = 1;
        cyc(1);
        // R11: reset state
        chk(!bus_req, "R11 bus_req after reset", {31'b0, bus_req}, 0);
        chk(!end_flag && !irq, "R11 flag and irq after reset", {30'b0, end_flag, irq}, 0);
        chk(cur_src == 0 && cur_dst == 0 && cur_cnt == 0, "R11 registers after reset", cur_src | cur_dst | {16'b0, cur_cnt}, 0);

        // Indirect byte transfers, source increment, destination fixed, ten in all
        master_en = 1;
        wr_cfg(0, 32'h0040_0000);
        wr_cfg(1, 32'h0000_F00B);
        wr_cfg(2, 32'd10);
        wr_cfg(3, ctl(1, 1, 2'd1, 2'd0, 2'd0, 0));
        for (int t = 0; t < 10; t++) run_xfer(1, 2'd1, 2'd0, 2'd0);
        chk(cur_src == 32'h0040_0028, "R3 indirect byte steps by 4", cur_src, 32'h0040_0028);
        chk(cur_dst == 32'h0000_F00B, "R4 fixed destination", cur_dst, 32'h0000_F00B);
        chk(end_flag, "R5 end flag at zero", {31'b0, end_flag}, 1);
        chk(!irq, "R6 irq masked", {31'b0, irq}, 0);
        nlog = 0; pulse_req(); cyc(20);
        chk(nlog == 0, "R5 request ignored after end", nlog, 0);
        wr_cfg(3, ctl(1, 1, 2'd1, 2'd0, 2'd0, 1));
        cyc(1);
        chk(irq, "R6 irq when enabled", {31'b0, irq}, 1);
        @(negedge clk); clr_end = 1; @(negedge clk); clr_end = 0;
        chk(!end_flag && !irq, "R6 clear drops flag and irq", {30'b0, end_flag, irq}, 0);

        // Direct halfword transfers: source decrement, destination increment
        wr_cfg(0, 32'h0000_0082);
        wr_cfg(1, 32'h0000_0200);
        wr_cfg(2, 32'd3);
        wr_cfg(3, ctl(1, 0, 2'd2, 2'd1, 2'd1, 0));
        for (int t = 0; t < 3; t++) run_xfer(0, 2'd2, 2'd1, 2'd1);
        chk(end_flag, "R5 end after three", {31'b0, end_flag}, 1);
        @(negedge clk); clr_end = 1; @(negedge clk); clr_end = 0;

        // R7: requests while disabled are dropped
        wr_cfg(2, 32'd4);
        master_en = 0;
        nlog = 0; pulse_req(); cyc(20);
        chk(nlog == 0, "R7 no access with master off", nlog, 0);
        master_en = 1; cyc(20);
        chk(nlog == 0, "R7 dropped request not serviced", nlog, 0);
        wr_cfg(3, ctl(0, 0, 2'd1, 2'd1, 2'd2, 0));
        pulse_req(); cyc(20);
        chk(nlog == 0, "R7 no access with channel off", nlog, 0);

        // R9: one request queued during a transfer, extras lost
        wr_cfg(0, 32'h0000_0010);
        wr_cfg(2, 32'd5);
        wr_cfg(3, ctl(1, 1, 2'd1, 2'd0, 2'd2, 0));
        s0 = 32'h0000_0010;
        nlog = 0;
        pulse_req();
        for (int i = 0; i < 50 && !bus_req; i++) @(negedge clk);
        pulse_req(); pulse_req();
        for (int i = 0; i < 300 && nlog < 6; i++) @(negedge clk);
        cyc(40);
        chk(nlog == 6, "R9 exactly two transfers", nlog, 6);
        chk(cur_cnt == 16'd3, "R9 count after queued request", {16'b0, cur_cnt}, 3);
        chk(la[3] == s0 + 4, "R9 queued transfer uses next pointer", la[3], s0 + 4);

        // Random configurations
        for (int t = 0; t < 40; t++) begin
            bit ind;
            logic [1:0] sm, dm, sz;
            ind = 1'($urandom);
            sm = 2'($urandom % 3); dm = 2'($urandom % 3); sz = 2'($urandom % 3);
            wr_cfg(0, $urandom);
            wr_cfg(1, $urandom);
            wr_cfg(2, 32'd100 + 32'(t));
            wr_cfg(3, ctl(1, ind, sm, dm, sz, 0));
            run_xfer(ind, sm, dm, sz);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule